// File: doc/BRIEF.md
# ARX Permutation Core

This block applies an iterated add-rotate-xor style permutation to a state of sixteen 32-bit words. The words are treated as a 4×4 matrix in row-major order, so row 0 holds words 0 to 3 and row 3 holds words 12 to 15. A caller presents the whole state in parallel together with a start pulse. The core then runs either a short or a long round schedule. Each round is a column step followed by a diagonal step, and one step is executed per clock.

Four quarter-round units work side by side on the four columns of the matrix. For a diagonal step, each row i is first rotated left by i word positions. The same column units then process the state, and the rows are rotated back afterwards, so the four units serve both kinds of step. The nonlinear mixing is carry-free: H(x,y) = (x xor y) xor ((x and y) shifted left by one). When the last step completes, the core raises a one-cycle done pulse. The result stays on the output until the next run is accepted.

Top module: `arx_perm_core`

## Requirements
- R1: When busy is low, a start sampled at a rising edge loads state_in and busy is high from the next cycle. A start seen while busy is high is ignored: it changes neither the result nor the timing of the run in progress.
- R2: long_mode is sampled together with an accepted start. Value 0 selects 4 rounds and value 1 selects 6 rounds. The input has no effect at other times.
- R3: done is high for exactly one cycle, 2·l clock cycles after the edge that accepted the start, where l is the selected round count. busy falls in the same cycle that done rises, and done is never high while busy is high.
- R4: A column step applies the quarter-round to the word groups (s0,s4,s8,s12), (s1,s5,s9,s13), (s2,s6,s10,s14) and (s3,s7,s11,s15), each listed as (a,b,c,d). Even-numbered steps (counting from 0) are column steps.
- R5: A diagonal step applies the quarter-round to the groups (s0,s5,s10,s15), (s1,s6,s11,s12), (s2,s7,s8,s13) and (s3,s4,s9,s14), each listed as (a,b,c,d). Odd-numbered steps are diagonal steps.
- R6: The quarter-round on (a,b,c,d) performs these updates in this order: a=H(a,b); d=rotr(a^d,8); c=H(c,d); b=rotr(c^b,11); a=H(a,b); d=rotr(a^d,16); c=H(c,d); b=rotr(c^b,31). Each rotr is a cyclic right rotation of a 32-bit word.
- R7: H(x,y) = (x^y)^((x&y)<<1), where the left shift is logical and drops bit 31.
- R8: While no run is in progress, state_out holds the result of the last completed run and stays unchanged until the next start is accepted.
- R9: An all-zero input state gives an all-zero output for both round counts.
- R10: After a synchronous active-high reset, busy and done are low and every word of state_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load state_in and begin a run |
| long_mode | input | 1 | Round count select: 0 gives 4 rounds, 1 gives 6 rounds |
| state_in | input | 16 × 32 | Input state, word i is element i |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| state_out | output | 16 × 32 | Permuted state, word i is element i |

## Verification
The assertions assume that reset is held for at least two clock edges before any start. They also assume that start, long_mode and state_in are stable around each rising edge, so that every start decision is a clean sample. The stimulus drives all inputs on the falling edge, holds reset for several cycles, and then issues starts at idle and at busy times, including a start held high across the done cycle. The checker tracks each run with its own cycle counter, measured against the round count sampled at acceptance, and it records whether the loaded state was all zero. The latency and zero-state properties therefore depend only on the values that were present when a start was accepted.

// File: rtl/arx_perm_pkg.sv
package arx_perm_pkg;

  // matrix geometry of the permutation state
  localparam int N_SIDE  = 4;
  localparam int N_WORDS = N_SIDE * N_SIDE;

  // kind of step executed in one clock
  typedef enum logic {
    STEP_COL  = 1'b0,
    STEP_DIAG = 1'b1
  } step_e;

endpackage

// File: rtl/arx_qround.sv
module arx_qround #(
  parameter int W  = 32,
  parameter int R0 = 8,
  parameter int R1 = 11,
  parameter int R2 = 16,
  parameter int R3 = 31
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] d_o
);

  // carry-free mixing (R7): top bit of the shifted AND term is dropped
  function automatic logic [W-1:0] mix(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x ^ y) ^ ((x & y) << 1);
  endfunction

  // cyclic right rotation by a constant amount
  function automatic logic [W-1:0] rotr(input logic [W-1:0] x, input int n);
    return (x >> n) | (x << (W - n));
  endfunction

  logic [W-1:0] a1, b1, c1, d1;
  logic [W-1:0] a2, b2, c2, d2;

  // eight dependent updates in fixed order (R6)
  assign a1 = mix(a_i, b_i);
  assign d1 = rotr(a1 ^ d_i, R0);
  assign c1 = mix(c_i, d1);
  assign b1 = rotr(c1 ^ b_i, R1);
  assign a2 = mix(a1, b1);
  assign d2 = rotr(a2 ^ d1, R2);
  assign c2 = mix(c1, d2);
  assign b2 = rotr(c2 ^ b1, R3);

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;

endmodule

// File: rtl/arx_row_rot.sv
module arx_row_rot
  import arx_perm_pkg::*;
#(
  parameter int W    = 32,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0] in_w  [N_WORDS],
  output logic [W-1:0] out_w [N_WORDS]
);

  // row r is rotated by r word positions; LEFT picks the direction
  for (genvar r = 0; r < N_SIDE; r++) begin : g_row
    for (genvar c = 0; c < N_SIDE; c++) begin : g_col
      if (LEFT) begin : g_left
        assign out_w[N_SIDE*r + c] = in_w[N_SIDE*r + ((c + r) % N_SIDE)];
      end else begin : g_right
        assign out_w[N_SIDE*r + ((c + r) % N_SIDE)] = in_w[N_SIDE*r + c];
      end
    end
  end

endmodule

// File: rtl/arx_perm_step.sv
module arx_perm_step
  import arx_perm_pkg::*;
#(
  parameter int W  = 32,
  parameter int R0 = 8,
  parameter int R1 = 11,
  parameter int R2 = 16,
  parameter int R3 = 31
) (
  input  logic [W-1:0] cur_w [N_WORDS],
  input  step_e        kind,
  output logic [W-1:0] nxt_w [N_WORDS]
);

  logic [W-1:0] skew_w   [N_WORDS];
  logic [W-1:0] pre_w    [N_WORDS];
  logic [W-1:0] mixed_w  [N_WORDS];
  logic [W-1:0] unskew_w [N_WORDS];

  // diagonals become columns after the left skew (R5)
  arx_row_rot #(.W(W), .LEFT(1'b1)) u_skew (
    .in_w  (cur_w),
    .out_w (skew_w)
  );

  always_comb begin
    for (int i = 0; i < N_WORDS; i++) begin
      pre_w[i] = (kind == STEP_DIAG) ? skew_w[i] : cur_w[i];
    end
  end

  // four shared column units (R4)
  for (genvar c = 0; c < N_SIDE; c++) begin : g_unit
    arx_qround #(.W(W), .R0(R0), .R1(R1), .R2(R2), .R3(R3)) u_qr (
      .a_i (pre_w[c]),
      .b_i (pre_w[N_SIDE + c]),
      .c_i (pre_w[2*N_SIDE + c]),
      .d_i (pre_w[3*N_SIDE + c]),
      .a_o (mixed_w[c]),
      .b_o (mixed_w[N_SIDE + c]),
      .c_o (mixed_w[2*N_SIDE + c]),
      .d_o (mixed_w[3*N_SIDE + c])
    );
  end

  arx_row_rot #(.W(W), .LEFT(1'b0)) u_unskew (
    .in_w  (mixed_w),
    .out_w (unskew_w)
  );

  always_comb begin
    for (int i = 0; i < N_WORDS; i++) begin
      nxt_w[i] = (kind == STEP_DIAG) ? unskew_w[i] : mixed_w[i];
    end
  end

endmodule

// File: rtl/arx_perm_ctrl.sv
module arx_perm_ctrl
  import arx_perm_pkg::*;
#(
  parameter int L_SHORT = 4,
  parameter int L_LONG  = 6
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  long_mode,
  output logic  load,
  output logic  step_en,
  output step_e kind,
  output logic  busy,
  output logic  done
);

  localparam int L_MAX    = (L_LONG > L_SHORT) ? L_LONG : L_SHORT;
  localparam int CW       = $clog2(2 * L_MAX);
  localparam int LAST_SH  = 2 * L_SHORT - 1;
  localparam int LAST_LG  = 2 * L_LONG - 1;

  logic [CW-1:0] step_q;
  logic [CW-1:0] last_q;
  logic          busy_q;
  logic          done_q;

  // a start is taken only when idle (R1)
  assign load    = start && !busy_q;
  assign step_en = busy_q;
  // even steps are column steps, odd steps diagonal steps (R4, R5)
  assign kind    = step_q[0] ? STEP_DIAG : STEP_COL;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        step_q <= '0;
        last_q <= long_mode ? CW'(LAST_LG) : CW'(LAST_SH);
      end else if (busy_q) begin
        if (step_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/arx_perm_core.sv
module arx_perm_core
  import arx_perm_pkg::*;
#(
  parameter int W       = 32,
  parameter int L_SHORT = 4,
  parameter int L_LONG  = 6,
  parameter int R0      = 8,
  parameter int R1      = 11,
  parameter int R2      = 16,
  parameter int R3      = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         long_mode,
  input  logic [W-1:0] state_in  [N_WORDS],
  output logic         busy,
  output logic         done,
  output logic [W-1:0] state_out [N_WORDS]
);

  logic         load;
  logic         step_en;
  step_e        kind;
  logic [W-1:0] st_q   [N_WORDS];
  logic [W-1:0] st_nxt [N_WORDS];

  arx_perm_ctrl #(.L_SHORT(L_SHORT), .L_LONG(L_LONG)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .long_mode (long_mode),
    .load      (load),
    .step_en   (step_en),
    .kind      (kind),
    .busy      (busy),
    .done      (done)
  );

  arx_perm_step #(.W(W), .R0(R0), .R1(R1), .R2(R2), .R3(R3)) u_step (
    .cur_w (st_q),
    .kind  (kind),
    .nxt_w (st_nxt)
  );

  // single state register: loaded on accept, updated once per step
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_WORDS; i++) st_q[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < N_WORDS; i++) st_q[i] <= state_in[i];
    end else if (step_en) begin
      for (int i = 0; i < N_WORDS; i++) st_q[i] <= st_nxt[i];
    end
  end

  assign state_out = st_q;

endmodule

// File: rtl/arx_perm_chk.sv
module arx_perm_chk
  import arx_perm_pkg::*;
#(
  parameter int W       = 32,
  parameter int L_SHORT = 4,
  parameter int L_LONG  = 6
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         long_mode,
  input logic [W-1:0] state_in  [N_WORDS],
  input logic         busy,
  input logic         done,
  input logic [W-1:0] state_out [N_WORDS]
);

  localparam int CNT_W = $clog2(2 * ((L_LONG > L_SHORT) ? L_LONG : L_SHORT) + 2);

  logic [N_WORDS*W-1:0] out_flat;
  logic [N_WORDS*W-1:0] in_flat;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_flat
    assign out_flat[i*W +: W] = state_out[i];
    assign in_flat[i*W +: W]  = state_in[i];
  end

  logic             track_q;
  logic             zero_q;
  logic [CNT_W-1:0] run_cnt_q;
  logic [CNT_W-1:0] run_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      track_q   <= 1'b0;
      zero_q    <= 1'b0;
      run_cnt_q <= '0;
      run_len_q <= '0;
    end else if (start && !busy) begin
      track_q   <= 1'b1;
      zero_q    <= (in_flat == '0);
      run_cnt_q <= '0;
      run_len_q <= long_mode ? CNT_W'(2 * L_LONG) : CNT_W'(2 * L_SHORT);
    end else if (track_q) begin
      if (done) track_q <= 1'b0;
      else      run_cnt_q <= run_cnt_q + 1'b1;
    end
  end

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && out_flat == '0));

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // the run length is fixed by long_mode at the accept edge (R2)
  p_done_due_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (track_q && run_cnt_q == run_len_q));

  p_due_done_r3: assert property (@(posedge clk) disable iff (rst)
    (track_q && run_cnt_q == run_len_q) |-> done);

  p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(out_flat));

  p_zero_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    (done && zero_q) |-> (out_flat == '0));

endmodule

bind arx_perm_core arx_perm_chk #(.W(W), .L_SHORT(L_SHORT), .L_LONG(L_LONG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .long_mode (long_mode),
  .state_in  (state_in),
  .busy      (busy),
  .done      (done),
  .state_out (state_out)
);

// File: tb/test_arx_perm_core.sv
`timescale 1ns/1ps
module test_arx_perm_core;

  typedef logic [31:0] st_t [16];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic long_mode = 1'b0;
  st_t  state_in;
  logic busy, done;
  st_t  state_out;

  int n_vec = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;

  arx_perm_core i_arx_perm_core (
    .clk(clk), .rst(rst), .start(start), .long_mode(long_mode),
    .state_in(state_in), .busy(busy), .done(done), .state_out(state_out)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] h_mix(logic [31:0] x, logic [31:0] y);
    logic [32:0] sh;
    sh = {1'b0, x & y} << 1;
    return (x ^ y) ^ sh[31:0];
  endfunction

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    logic [63:0] dbl;
    dbl = {x, x} >> n;
    return dbl[31:0];
  endfunction

  function automatic st_t ref_perm(st_t s_in, int rounds);
    st_t s;
    int grp [4];
    logic [31:0] a, b, c, d;
    s = s_in;
    for (int k = 0; k < 2 * rounds; k++) begin
      for (int j = 0; j < 4; j++) begin
        if (k % 2 == 0) begin // column groups (R4)
          grp[0] = j; grp[1] = j + 4; grp[2] = j + 8; grp[3] = j + 12;
        end else begin        // diagonal groups (R5)
          grp[0] = j; grp[1] = 4 + (j + 1) % 4;
          grp[2] = 8 + (j + 2) % 4; grp[3] = 12 + (j + 3) % 4;
        end
        a = s[grp[0]]; b = s[grp[1]]; c = s[grp[2]]; d = s[grp[3]];
        a = h_mix(a, b); d = rr(a ^ d, 8);  c = h_mix(c, d); b = rr(c ^ b, 11);
        a = h_mix(a, b); d = rr(a ^ d, 16); c = h_mix(c, d); b = rr(c ^ b, 31);
        s[grp[0]] = a; s[grp[1]] = b; s[grp[2]] = c; s[grp[3]] = d;
      end
    end
    return s;
  endfunction

  // cycle model of busy/done/output
  logic m_busy, m_done;
  int   m_rem;
  st_t  m_out, m_pend;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_rem <= 0;
      for (int i = 0; i < 16; i++) m_out[i] <= '0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        m_busy <= 1'b1;
        m_rem  <= long_mode ? 12 : 8;
        m_pend <= ref_perm(state_in, long_mode ? 6 : 4);
      end else if (m_busy) begin
        if (m_rem == 1) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_out <= m_pend;
        end
        m_rem <= m_rem - 1;
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_state(string req, string what, st_t act, st_t exp);
    int bad_i;
    bad_i = -1;
    for (int i = 0; i < 16; i++) if (act[i] !== exp[i] && bad_i < 0) bad_i = i;
    if (bad_i < 0) check(1'b1, req, what, 32'h0, 32'h0);
    else check(1'b0, req, $sformatf("%s word %0d", what, bad_i), act[bad_i], exp[bad_i]);
  endtask

  // per-clock comparison against the cycle model
  always @(negedge clk) begin
    if (chk_on) begin
      check(busy === m_busy, "R3", "busy", 32'(busy), 32'(m_busy));
      check(done === m_done, "R3", "done", 32'(done), 32'(m_done));
      if (!m_busy) check_state("R8", "idle output", state_out, m_out);
    end
  end

  function automatic st_t rnd_state();
    st_t s;
    for (int i = 0; i < 16; i++) s[i] = $urandom;
    return s;
  endfunction

  task automatic run(st_t s, bit lm, string req);
    @(negedge clk);
    start = 1'b1; state_in = s; long_mode = lm;
    @(negedge clk);
    start = 1'b0; long_mode = ~lm; state_in = rnd_state(); // R2: no effect after accept
    while (busy) @(negedge clk);
    check_state(req, lm ? "six-round result" : "four-round result",
                state_out, ref_perm(s, lm ? 6 : 4));
  endtask

  st_t zero_s, sa, sb, sc;

  initial begin
    for (int i = 0; i < 16; i++) begin state_in[i] = '0; zero_s[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(busy === 1'b0, "R10", "busy after reset", 32'(busy), 32'h0);
    check(done === 1'b0, "R10", "done after reset", 32'(done), 32'h0);
    check_state("R10", "output after reset", state_out, zero_s);
    chk_on = 1'b1;

    // R9: zero state is a fixed point for both round counts
    run(zero_s, 1'b0, "R9");
    run(zero_s, 1'b1, "R9");

    // R2 R4 R5 R6 R7: random states under both round counts
    for (int t = 0; t < 24; t++) run(rnd_state(), t[0], "R6 R7");
    for (int t = 0; t < 4; t++) begin
      sa = rnd_state();
      sa[t] = 32'hFFFF_FFFF; sa[t+4] = 32'h8000_0001; // top-bit drop of H (R7)
      run(sa, 1'b1, "R4 R5");
    end

    // R1: start while busy is ignored
    sa = rnd_state(); sb = rnd_state();
    @(negedge clk);
    start = 1'b1; state_in = sa; long_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; state_in = sb; long_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    check_state("R1", "result after busy start", state_out, ref_perm(sa, 4));

    // R1 R3: start held across done is taken again at once
    sa = rnd_state(); sc = rnd_state();
    @(negedge clk);
    start = 1'b1; state_in = sa; long_mode = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    check_state("R3", "first back-to-back result", state_out, ref_perm(sa, 6));
    state_in = sc; long_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R1", "re-accept on done cycle", 32'(busy), 32'h1);
    while (busy) @(negedge clk);
    check_state("R3", "second back-to-back result", state_out, ref_perm(sc, 4));

    // R8: long idle stretch with changing inputs, output held
    for (int t = 0; t < 20; t++) begin
      state_in = rnd_state(); long_mode = t[0];
      @(negedge clk);
    end
    check_state("R8", "output after idle", state_out, ref_perm(sc, 4));

    chk_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule